// File: doc/BRIEF.md
# Management Frame Command Engine

This block carries out clause-22 style management transactions in a single register access. The host writes one 32-bit frame word. The engine splits the word into its fields and checks the start code and the PHY address. If both are valid, it runs the read or write opcode against a built-in set of 32 sixteen-bit PHY registers. It then stores the completed word, with turnaround bit 16 set, where the host can read it back. No serial MDIO shifting takes place, and every command finishes in the cycle of the write.

Writes to the control register (PHY register 0) have side effects. A software reset clears itself and turns on autonegotiation. An autonegotiation restart clears itself and reports negotiation complete, plus link and partner ability when the link is up.

Next to the engine sit three other registers:
- a configuration register whose two transceiver-present bits cannot be written;
- a 16-bit interrupt status register that clears when read;
- a 16-bit interrupt mask register.

A level interrupt output follows any status bit that is set while its mask bit is 0. A link-up input feeds the PHY model. Each change on that input updates the link bits and fills the status register with ones.

Top module: `mgmt_frame_engine`

## Requirements
- R1: Register map by word address: 0 is the frame word, 1 is configuration, 2 is the interrupt mask, 3 is the interrupt status. Reads of any other address return 0. Every write to address 0 stores the written word with bit 16 set; the frame word resets to 0.
- R2: The frame word fields are start [31:30], opcode [29:28], PHY address [27:23], register [22:18], turnaround [17:16] and data [15:0]. A command runs only when start is 01 and the PHY address equals PHY_ADDR (default 1). Otherwise no PHY register changes and the stored data field is the written one.
- R3: Opcode 10 (read) replaces stored bits [15:0] with the addressed PHY register. Opcodes 00 and 11 change no PHY register and keep the written data field.
- R4: Opcode 01 (write) stores the data field into the addressed PHY register and leaves every other register unchanged.
- R5: A write to PHY register 0 with bit 15 (reset) set stores the value with bit 15 cleared and bit 12 (autonegotiation enable) set.
- R6: A write to PHY register 0 with bit 9 (restart) set stores bit 9 cleared and sets bit 5 of register 1. If link_up is 1, it also sets bit 2 of register 1 and bit 8 of register 5.
- R7: After reset, PHY register 1 reads 0x4028 and register 4 reads 0x0100. All other PHY registers read 0.
- R8: Configuration bits 9:8 ignore host writes; bit 8 is 1 and bit 9 is 0 after reset. All other configuration bits reset to 0 and store what is written.
- R9: A read of the status register returns its value and clears it to 0. Writes to the status register have no effect. A link event in the same cycle as a status read wins over the clear.
- R10: The mask resets to 0xFFFF. irq is 1 exactly when some status bit is 1 while the same mask bit is 0.
- R11: A change on link_up copies the new level into bit 2 of PHY register 1 and bit 8 of PHY register 5, and sets the status register to 0xFFFF. This takes effect one cycle after the change and overrides a same-cycle PHY write to those bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Word address of the register access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the current address, valid in the same cycle |
| link_up | input | 1 | Link state presented to the PHY model |
| irq | output | 1 | Masked interrupt level |

## Verification
The bench probes the frame check with three invalid cases: a bad start code, a foreign PHY address and the two idle opcodes. Each must leave the PHY registers untouched and still come back with the turnaround bit set. A design that ran the command anyway would leave a written value behind in the target register, and one that skipped the turnaround bit would return the raw word.

The control-register side effects are tried with the link both down and up. A design that missed the link condition would report link status too early or never. The tests also cover the clear-on-read status, an ignored status write, the masked interrupt, and the locked transceiver bits. A wrong design would keep the interrupt asserted, let a write disturb the status, or flip bits 9:8.

// File: rtl/mfe_pkg.sv
package mfe_pkg;

  typedef struct packed {
    logic [1:0]  start;
    logic [1:0]  opc;
    logic [4:0]  phy;
    logic [4:0]  regad;
    logic [1:0]  ta;
    logic [15:0] data;
  } mgmt_frame_t;

  localparam logic [1:0] START_OK = 2'b01;
  localparam logic [1:0] OPC_WR   = 2'b01;
  localparam logic [1:0] OPC_RD   = 2'b10;

  // PHY register bit positions
  localparam int CTL_RESET   = 15;
  localparam int CTL_AN_EN   = 12;
  localparam int CTL_AN_RST  = 9;
  localparam int STS_AN_DONE = 5;
  localparam int STS_LINK    = 2;
  localparam int LPA_TXFD    = 8;

  localparam logic [15:0] STS_RESET = 16'h4028;
  localparam logic [15:0] ADV_RESET = 16'h0100;

  // Value actually stored by a control-register write
  function automatic logic [15:0] ctl_store(input logic [15:0] d);
    logic [15:0] v;
    v = d;
    if (d[CTL_RESET]) begin
      v[CTL_RESET] = 1'b0;
      v[CTL_AN_EN] = 1'b1;
    end
    v[CTL_AN_RST] = 1'b0;
    return v;
  endfunction

  function automatic logic frame_valid(input mgmt_frame_t f, input logic [4:0] own);
    return (f.start == START_OK) && (f.phy == own);
  endfunction

  // Completed frame word as stored for host readback
  function automatic logic [31:0] frame_done(input mgmt_frame_t f, input logic ok,
                                             input logic [15:0] rd);
    mgmt_frame_t w;
    w = f;
    w.ta[0] = 1'b1;
    if (ok && f.opc == OPC_RD) w.data = rd;
    return w;
  endfunction

  function automatic logic [15:0] phy_reset_value(input int idx);
    case (idx)
      1:       return STS_RESET;
      4:       return ADV_RESET;
      default: return 16'h0000;
    endcase
  endfunction

endpackage

// File: rtl/mfe_phy_regs.sv
module mfe_phy_regs
  import mfe_pkg::*;
#(
  parameter int NREG = 32,
  localparam int RAW = $clog2(NREG)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [RAW-1:0] rd_addr,
  output logic [15:0]    rd_data,
  input  logic           wr_en,
  input  logic [RAW-1:0] wr_addr,
  input  logic [15:0]    wr_data,
  input  logic           link_up,
  input  logic           link_evt,
  output logic [15:0]    ctl_q
);

  logic [15:0] regs [NREG];
  logic [15:0] nxt  [NREG];

  always_comb begin
    nxt = regs;
    if (wr_en) begin
      if (wr_addr == '0) begin
        nxt[0] = ctl_store(wr_data);
        if (wr_data[CTL_AN_RST]) begin
          nxt[1][STS_AN_DONE] = 1'b1;
          if (link_up) begin
            nxt[1][STS_LINK] = 1'b1;
            nxt[5][LPA_TXFD] = 1'b1;
          end
        end
      end else begin
        nxt[wr_addr] = wr_data;
      end
    end
    if (link_evt) begin
      nxt[1][STS_LINK] = link_up;
      nxt[5][LPA_TXFD] = link_up;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) regs[i] <= phy_reset_value(i);
    end else begin
      regs <= nxt;
    end
  end

  assign rd_data = regs[rd_addr];
  assign ctl_q   = regs[0];

endmodule

// File: rtl/mfe_frame_ctrl.sv
module mfe_frame_ctrl
  import mfe_pkg::*;
#(
  parameter int PHY_ADDR = 1,
  parameter int NREG     = 32,
  localparam int RAW = $clog2(NREG)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           frame_wr,
  input  logic [31:0]    wdata,
  output logic [RAW-1:0] phy_rd_addr,
  input  logic [15:0]    phy_rd_data,
  output logic           phy_wr_en,
  output logic [RAW-1:0] phy_wr_addr,
  output logic [15:0]    phy_wr_data,
  output logic [31:0]    frame_q
);

  mgmt_frame_t f;
  logic        ok;

  assign f           = mgmt_frame_t'(wdata);
  assign ok          = frame_valid(f, 5'(PHY_ADDR));
  assign phy_rd_addr = f.regad[RAW-1:0];
  assign phy_wr_addr = f.regad[RAW-1:0];
  assign phy_wr_data = f.data;
  assign phy_wr_en   = frame_wr && ok && (f.opc == OPC_WR);

  always_ff @(posedge clk) begin
    if (!rst_n)        frame_q <= '0;
    else if (frame_wr) frame_q <= frame_done(f, ok, phy_rd_data);
  end

endmodule

// File: rtl/mfe_irq_ctrl.sv
module mfe_irq_ctrl (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        mask_wr,
  input  logic [15:0] mask_wdata,
  input  logic        stat_rd,
  input  logic        link_evt,
  output logic [15:0] mask_q,
  output logic [15:0] stat_q,
  output logic        irq
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q <= 16'hFFFF;
      stat_q <= 16'h0000;
    end else begin
      if (mask_wr) mask_q <= mask_wdata;
      if (link_evt)     stat_q <= 16'hFFFF;
      else if (stat_rd) stat_q <= 16'h0000;
    end
  end

  assign irq = |(stat_q & ~mask_q);

endmodule

// File: rtl/mgmt_frame_engine.sv
module mgmt_frame_engine #(
  parameter int ADDR_W   = 4,
  parameter int PHY_ADDR = 1,
  parameter int NREG     = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              link_up,
  output logic              irq
);

  localparam int RAW = $clog2(NREG);
  localparam logic [ADDR_W-1:0] A_FRAME = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_CFG   = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_MASK  = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_STAT  = ADDR_W'(3);

  // Named internal events
  logic frame_wr, cfg_wr, mask_wr, stat_rd, link_evt;
  logic link_q;
  logic [31:0] cfg_q, frame_q;
  logic [15:0] mask_q, stat_q, ctl_q, phy_rd_data, phy_wr_data;
  logic [RAW-1:0] phy_rd_addr, phy_wr_addr;
  logic phy_wr_en;

  assign frame_wr = bus_wr && (bus_addr == A_FRAME);
  assign cfg_wr   = bus_wr && (bus_addr == A_CFG);
  assign mask_wr  = bus_wr && (bus_addr == A_MASK);
  assign stat_rd  = bus_rd && (bus_addr == A_STAT);
  assign link_evt = link_up ^ link_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      link_q <= 1'b0;
      cfg_q  <= 32'h0000_0100;
    end else begin
      link_q <= link_up;
      if (cfg_wr) cfg_q <= {bus_wdata[31:10], cfg_q[9:8], bus_wdata[7:0]};
    end
  end

  mfe_frame_ctrl #(.PHY_ADDR(PHY_ADDR), .NREG(NREG)) u_frame (
    .clk, .rst_n, .frame_wr, .wdata(bus_wdata),
    .phy_rd_addr, .phy_rd_data, .phy_wr_en, .phy_wr_addr, .phy_wr_data, .frame_q
  );

  mfe_phy_regs #(.NREG(NREG)) u_phy (
    .clk, .rst_n, .rd_addr(phy_rd_addr), .rd_data(phy_rd_data),
    .wr_en(phy_wr_en), .wr_addr(phy_wr_addr), .wr_data(phy_wr_data),
    .link_up, .link_evt, .ctl_q
  );

  mfe_irq_ctrl u_irq (
    .clk, .rst_n, .mask_wr, .mask_wdata(bus_wdata[15:0]), .stat_rd, .link_evt,
    .mask_q, .stat_q, .irq
  );

  always_comb begin
    case (bus_addr)
      A_FRAME: bus_rdata = frame_q;
      A_CFG:   bus_rdata = cfg_q;
      A_MASK:  bus_rdata = {16'h0000, mask_q};
      A_STAT:  bus_rdata = {16'h0000, stat_q};
      default: bus_rdata = 32'h0;
    endcase
  end

endmodule

// File: rtl/mfe_checker.sv
module mfe_checker #(
  parameter int RAW = 5
) (
  input logic           clk,
  input logic           rst_n,
  input logic           frame_wr,
  input logic           cfg_wr,
  input logic           stat_rd,
  input logic           link_evt,
  input logic [31:0]    bus_wdata,
  input logic [31:0]    frame_q,
  input logic [31:0]    cfg_q,
  input logic [15:0]    stat_q,
  input logic [15:0]    mask_q,
  input logic [15:0]    ctl_q,
  input logic           phy_wr_en,
  input logic [RAW-1:0] phy_wr_addr,
  input logic           irq
);

  AST_TA_SET: assert property (@(posedge clk) disable iff (!rst_n)
    frame_wr |=> frame_q[16]); // R1

  AST_BAD_START_NOCMD: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_wr && bus_wdata[31:30] != 2'b01) |-> !phy_wr_en); // R2

  AST_CTL_SELFCLR: assert property (@(posedge clk) disable iff (!rst_n)
    (phy_wr_en && phy_wr_addr == '0) |=> (!ctl_q[15] && !ctl_q[9])); // R5

  AST_CFG_RO: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr |=> cfg_q[9:8] == $past(cfg_q[9:8])); // R8

  AST_STAT_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !link_evt) |=> stat_q == 16'h0000); // R9

  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == 16'hFFFF) |-> !irq); // R10

  AST_LINK_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    link_evt |=> stat_q == 16'hFFFF); // R11

endmodule

bind mgmt_frame_engine mfe_checker #(.RAW(RAW)) u_chk (
  .clk, .rst_n, .frame_wr, .cfg_wr, .stat_rd, .link_evt, .bus_wdata,
  .frame_q, .cfg_q, .stat_q, .mask_q, .ctl_q, .phy_wr_en, .phy_wr_addr, .irq
);

// File: tb/mgmt_frame_engine_tb.sv
module mgmt_frame_engine_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        link_up = 1'b0;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk; // 125 MHz

  mgmt_frame_engine u_dut (
    .clk, .rst_n, .bus_addr, .bus_wr, .bus_rd, .bus_wdata, .bus_rdata, .link_up, .irq
  );

  function automatic logic [31:0] mk(input logic [1:0] st, input logic [1:0] op,
                                     input logic [4:0] phy, input logic [4:0] rg,
                                     input logic [15:0] d);
    return {st, op, phy, rg, 2'b00, d};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic phy_read(input logic [4:0] rg, output logic [15:0] d);
    logic [31:0] w;
    bus_write(4'd0, mk(2'b01, 2'b10, 5'd1, rg, 16'h0));
    bus_read(4'd0, w);
    d = w[15:0];
  endtask

  task automatic phy_write(input logic [4:0] rg, input logic [15:0] d);
    bus_write(4'd0, mk(2'b01, 2'b01, 5'd1, rg, d));
  endtask

  task automatic t_reset;
    logic [31:0] v; logic [15:0] p;
    bus_read(4'd0, v); check("R1 frame reset", v, 32'h0);
    bus_read(4'd1, v); check("R8 cfg reset", v, 32'h100);
    bus_read(4'd2, v); check("R10 mask reset", v, 32'hFFFF);
    bus_read(4'd3, v); check("R9 status reset", v, 32'h0);
    check("R10 irq reset", {31'b0, irq}, 32'h0);
    phy_read(5'd1, p); check("R7 reg1 reset", {16'h0, p}, 32'h4028);
    phy_read(5'd4, p); check("R7 reg4 reset", {16'h0, p}, 32'h0100);
    phy_read(5'd7, p); check("R7 reg7 reset", {16'h0, p}, 32'h0);
  endtask

  task automatic t_map_cfg;
    logic [31:0] v;
    bus_write(4'd1, 32'hA5A5_0205);
    bus_read(4'd1, v); check("R8 cfg ro bits", v, 32'hA5A5_0105);
    bus_write(4'd1, 32'h0);
    bus_read(4'd1, v); check("R8 cfg bit8 held", v, 32'h100);
    bus_write(4'd3, 32'h1234);
    bus_read(4'd3, v); check("R9 status write ignored", v, 32'h0);
    bus_read(4'd9, v); check("R1 unmapped read", v, 32'h0);
  endtask

  task automatic t_frames;
    logic [31:0] v, w; logic [15:0] p;
    phy_write(5'd3, 16'hBEEF);
    bus_read(4'd0, v); check("R1 write frame ta", v, mk(2'b01, 2'b01, 5'd1, 5'd3, 16'hBEEF) | 32'h10000);
    phy_read(5'd3, p); check("R4 reg3 written", {16'h0, p}, 32'hBEEF);
    phy_read(5'd1, p); check("R4 reg1 untouched", {16'h0, p}, 32'h4028);
    w = mk(2'b01, 2'b10, 5'd1, 5'd3, 16'h0);
    bus_write(4'd0, w); bus_read(4'd0, v);
    check("R3 read frame", v, {w[31:16] | 16'h0001, 16'hBEEF});
    w = mk(2'b00, 2'b01, 5'd1, 5'd3, 16'h1111);
    bus_write(4'd0, w); bus_read(4'd0, v); check("R2 bad start ta", v, w | 32'h10000);
    phy_read(5'd3, p); check("R2 bad start no write", {16'h0, p}, 32'hBEEF);
    w = mk(2'b01, 2'b01, 5'd2, 5'd3, 16'h2222);
    bus_write(4'd0, w); bus_read(4'd0, v); check("R2 bad phy ta", v, w | 32'h10000);
    phy_read(5'd3, p); check("R2 bad phy no write", {16'h0, p}, 32'hBEEF);
    w = mk(2'b01, 2'b00, 5'd1, 5'd3, 16'h3333);
    bus_write(4'd0, w); bus_read(4'd0, v); check("R3 idle opcode word", v, w | 32'h10000);
    w = mk(2'b01, 2'b11, 5'd1, 5'd3, 16'h4444);
    bus_write(4'd0, w); bus_read(4'd0, v); check("R3 opcode 11 word", v, w | 32'h10000);
    phy_read(5'd3, p); check("R3 idle opcodes no write", {16'h0, p}, 32'hBEEF);
  endtask

  task automatic t_ctl;
    logic [15:0] p;
    phy_write(5'd0, 16'h8000);
    phy_read(5'd0, p); check("R5 reset self clear", {16'h0, p}, 32'h1000);
    phy_write(5'd1, 16'h0);
    phy_write(5'd0, 16'h0200);
    phy_read(5'd0, p); check("R6 restart self clear", {16'h0, p}, 32'h0);
    phy_read(5'd1, p); check("R6 link down reg1", {16'h0, p}, 32'h0020);
    phy_read(5'd5, p); check("R6 link down reg5", {16'h0, p}, 32'h0);
  endtask

  task automatic t_link;
    logic [31:0] v; logic [15:0] p;
    @(negedge clk); link_up = 1'b1;
    @(negedge clk);
    check("R10 irq masked", {31'b0, irq}, 32'h0);
    bus_read(4'd3, v); check("R11 status fill", v, 32'hFFFF);
    bus_read(4'd3, v); check("R9 status cleared", v, 32'h0);
    phy_read(5'd1, p); check("R11 reg1 link", {16'h0, p}, 32'h0024);
    phy_read(5'd5, p); check("R11 reg5 ability", {16'h0, p}, 32'h0100);
    phy_write(5'd1, 16'h0); phy_write(5'd5, 16'h0);
    phy_write(5'd0, 16'h0200);
    phy_read(5'd1, p); check("R6 link up reg1", {16'h0, p}, 32'h0024);
    phy_read(5'd5, p); check("R6 link up reg5", {16'h0, p}, 32'h0100);
  endtask

  task automatic t_irq;
    logic [31:0] v; logic [15:0] p;
    bus_write(4'd2, 32'h0000_FFFE);
    check("R10 irq idle", {31'b0, irq}, 32'h0);
    @(negedge clk); link_up = 1'b0;
    @(negedge clk);
    check("R10 irq asserted", {31'b0, irq}, 32'h1);
    bus_read(4'd3, v); check("R9 status read value", v, 32'hFFFF);
    check("R10 irq after clear", {31'b0, irq}, 32'h0);
    phy_read(5'd1, p); check("R11 reg1 link down", {16'h0, p}, 32'h0020);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_map_cfg();
    t_frames();
    t_ctl();
    t_link();
    t_irq();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule